// File: doc/BRIEF.md
# Integer and Control Register State

This block holds the integer and control architectural state of a 64-bit processor core: a 64-entry general register file, a 32-bit status word, an array of 64-bit control registers, the program counter and a one-bit instruction-set-mode flag. Each store has a synchronous write port and a combinational read port. A decode stage drives the read addresses and sees the values in the same cycle. Writeback drives the write ports, and they take effect at the next rising clock edge.

The general registers can be reached in two ways. The wide port covers all 64 entries at full width. The narrow port covers only entries 0 to 15, reads their low 32 bits, and sign-extends on write. The top entry is wired to zero. Control register 0 has no storage of its own: it is a 64-bit window onto the status word. Six status flags have a bit-level port, so one flag can be changed without a read-modify-write. A PC write splits the value: its low bit becomes the mode flag, and the PC keeps an even address.

Top module: `arch_int_state`

## Requirements
- R1: A synchronous active-high reset clears every general register, every control register, the status word, the PC and the mode flag to zero.
- R2: A wide write to an index from 0 to 62 stores the 64-bit value, which the wide read port returns from the next cycle. In the cycle of the write, a read of the same index returns the old value.
- R3: A read of general register index 63 always returns zero, and a write to index 63 has no effect.
- R4: A narrow read at index n (0 to 15) returns bits 31:0 of general register n.
- R5: A narrow write stores its 32-bit value sign-extended to 64 bits. When a wide write and a narrow write target the same register in one cycle, the narrow write wins.
- R6: A read of control register index 0 returns the status word zero-extended to 64 bits. A write to index 0 loads bits 31:0 of the data into the status word. All other control indices are ordinary 64-bit storage.
- R7: A whole-word status write loads the status word. It takes priority over a control-register-0 write in the same cycle.
- R8: Flag select codes map to status bits as follows: 0 to bit 14 (FP bank), 1 to bit 13 (FP transfer size), 2 to bit 12 (FP precision), 3 to bit 9 (divide M), 4 to bit 8 (divide Q), 5 to bit 1 (MAC saturation). The flag read output carries the bit for code k at position k. A flag write changes only its own bit, and codes 6 and 7 change nothing.
- R9: When a flag write and a whole-word status write occur in the same cycle, the whole word is loaded and the flag write then sets its one bit.
- R10: A PC write loads the PC with the value's bit 0 cleared, and loads the mode flag with the value's bit 0.
- R11: The mode flag changes only through a PC write. Writes to any other port leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| gr_we | input | 1 | Wide general register write enable |
| gr_waddr | input | 6 | Wide write index |
| gr_wdata | input | 64 | Wide write data |
| gr_raddr | input | 6 | Wide read index |
| gr_rdata | output | 64 | Wide read data |
| nr_we | input | 1 | Narrow write enable |
| nr_waddr | input | 4 | Narrow write index |
| nr_wdata | input | 32 | Narrow write data |
| nr_raddr | input | 4 | Narrow read index |
| nr_rdata | output | 32 | Narrow read data |
| cr_we | input | 1 | Control register write enable |
| cr_waddr | input | 4 | Control register write index |
| cr_wdata | input | 64 | Control register write data |
| cr_raddr | input | 4 | Control register read index |
| cr_rdata | output | 64 | Control register read data |
| sr_we | input | 1 | Whole status word write enable |
| sr_wdata | input | 32 | Status word write data |
| sr_rdata | output | 32 | Status word |
| flg_we | input | 1 | Single flag write enable |
| flg_sel | input | 3 | Flag select code |
| flg_wdata | input | 1 | Flag write value |
| flg_rdata | output | 6 | All six flags, bit k for code k |
| pc_we | input | 1 | PC write enable |
| pc_wdata | input | 64 | PC write value, bit 0 is the mode |
| pc_rdata | output | 64 | Program counter |
| mode | output | 1 | Instruction-set-mode flag |

## Verification
A table of wide writes, each read back, covers ordinary indices, the top-zero index, and data with zero, all-ones and sign-bit patterns. These separate plain storage from the zero rule. Narrow writes use values with the sign bit set and clear, which shows real sign extension rather than zero fill. Same-cycle write pairs (wide against narrow, status against control 0, flag against status word) pin down each priority order. Flag writes on an all-ones and on an all-zeros status word, including the unused codes, show whether neighbouring bits survive. PC writes with odd and even values, followed by writes to other ports, show whether the mode follows only bit 0 of a PC write.

// File: rtl/arch_int_state.sv
module arch_int_state #(
  parameter int GR_N = 64,
  parameter int CR_N = 16,
  parameter int XLEN = 64,
  parameter int NW   = 32,
  parameter int NR_N = 16,
  localparam int GA_W = $clog2(GR_N),
  localparam int CA_W = $clog2(CR_N),
  localparam int NA_W = $clog2(NR_N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gr_we,
  input  logic [GA_W-1:0] gr_waddr,
  input  logic [XLEN-1:0] gr_wdata,
  input  logic [GA_W-1:0] gr_raddr,
  output logic [XLEN-1:0] gr_rdata,
  input  logic            nr_we,
  input  logic [NA_W-1:0] nr_waddr,
  input  logic [NW-1:0]   nr_wdata,
  input  logic [NA_W-1:0] nr_raddr,
  output logic [NW-1:0]   nr_rdata,
  input  logic            cr_we,
  input  logic [CA_W-1:0] cr_waddr,
  input  logic [XLEN-1:0] cr_wdata,
  input  logic [CA_W-1:0] cr_raddr,
  output logic [XLEN-1:0] cr_rdata,
  input  logic            sr_we,
  input  logic [NW-1:0]   sr_wdata,
  output logic [NW-1:0]   sr_rdata,
  input  logic            flg_we,
  input  logic [2:0]      flg_sel,
  input  logic            flg_wdata,
  output logic [5:0]      flg_rdata,
  input  logic            pc_we,
  input  logic [XLEN-1:0] pc_wdata,
  output logic [XLEN-1:0] pc_rdata,
  output logic            mode
);

  localparam logic [GA_W-1:0] ZERO_IDX = GA_W'(GR_N - 1);

  logic [XLEN-1:0] gr [GR_N];
  logic [XLEN-1:0] cr [CR_N];
  logic [NW-1:0]   sr, sr_nxt;
  logic [XLEN-1:0] pc;
  logic            ism;

  function automatic int flag_pos(input logic [2:0] s);
    case (s)
      3'd0:    return 14;
      3'd1:    return 13;
      3'd2:    return 12;
      3'd3:    return 9;
      3'd4:    return 8;
      default: return 1;
    endcase
  endfunction

  wire cr0_wr = cr_we && cr_waddr == '0;
  wire [XLEN-1:0] nr_sext = {{(XLEN-NW){nr_wdata[NW-1]}}, nr_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < GR_N; i++) gr[i] <= '0;
    end else begin
      if (gr_we && gr_waddr != ZERO_IDX) gr[gr_waddr] <= gr_wdata;
      if (nr_we) gr[GA_W'(nr_waddr)] <= nr_sext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CR_N; i++) cr[i] <= '0;
    end else if (cr_we && cr_waddr != '0) begin
      cr[cr_waddr] <= cr_wdata;
    end
  end

  always_comb begin
    sr_nxt = sr;
    if (cr0_wr) sr_nxt = cr_wdata[NW-1:0];
    if (sr_we) sr_nxt = sr_wdata;
    if (flg_we && flg_sel < 3'd6) sr_nxt[flag_pos(flg_sel)] = flg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      pc  <= '0;
      ism <= 1'b0;
    end else begin
      sr <= sr_nxt;
      if (pc_we) begin
        pc  <= {pc_wdata[XLEN-1:1], 1'b0};
        ism <= pc_wdata[0];
      end
    end
  end

  assign gr_rdata  = (gr_raddr == ZERO_IDX) ? '0 : gr[gr_raddr];
  assign nr_rdata  = gr[GA_W'(nr_raddr)][NW-1:0];
  assign cr_rdata  = (cr_raddr == '0) ? {{(XLEN-NW){1'b0}}, sr} : cr[cr_raddr];
  assign sr_rdata  = sr;
  assign flg_rdata = {sr[1], sr[8], sr[9], sr[12], sr[13], sr[14]};
  assign pc_rdata  = pc;
  assign mode      = ism;

  a_r3_top_reads_zero: assert property (@(posedge clk) disable iff (rst)
    gr_raddr == ZERO_IDX |-> gr_rdata == '0);

  a_r5_narrow_sign_ext: assert property (@(posedge clk) disable iff (rst)
    nr_we |=> gr[GA_W'($past(nr_waddr))] == {{(XLEN-NW){$past(nr_wdata[NW-1])}}, $past(nr_wdata)});

  a_r8_flag_single_bit: assert property (@(posedge clk) disable iff (rst)
    (flg_we && !sr_we && !cr0_wr) |=> $countones(sr ^ $past(sr)) <= 1);

  a_r10_pc_split: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> (mode == $past(pc_wdata[0])) && (pc_rdata[0] == 1'b0));

  a_r11_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !pc_we |=> $stable(mode));

endmodule

// File: tb/test_arch_int_state.sv
module test_arch_int_state;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gr_we = 0;
  logic [5:0]  gr_waddr = 0, gr_raddr = 0;
  logic [63:0] gr_wdata = 0, gr_rdata;
  logic        nr_we = 0;
  logic [3:0]  nr_waddr = 0, nr_raddr = 0;
  logic [31:0] nr_wdata = 0, nr_rdata;
  logic        cr_we = 0;
  logic [3:0]  cr_waddr = 0, cr_raddr = 0;
  logic [63:0] cr_wdata = 0, cr_rdata;
  logic        sr_we = 0;
  logic [31:0] sr_wdata = 0, sr_rdata;
  logic        flg_we = 0;
  logic [2:0]  flg_sel = 0;
  logic        flg_wdata = 0;
  logic [5:0]  flg_rdata;
  logic        pc_we = 0;
  logic [63:0] pc_wdata = 0, pc_rdata;
  logic        mode;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arch_int_state i_arch_int_state (
    .clk(clk), .rst(rst),
    .gr_we(gr_we), .gr_waddr(gr_waddr), .gr_wdata(gr_wdata), .gr_raddr(gr_raddr), .gr_rdata(gr_rdata),
    .nr_we(nr_we), .nr_waddr(nr_waddr), .nr_wdata(nr_wdata), .nr_raddr(nr_raddr), .nr_rdata(nr_rdata),
    .cr_we(cr_we), .cr_waddr(cr_waddr), .cr_wdata(cr_wdata), .cr_raddr(cr_raddr), .cr_rdata(cr_rdata),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .flg_we(flg_we), .flg_sel(flg_sel), .flg_wdata(flg_wdata), .flg_rdata(flg_rdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_rdata(pc_rdata), .mode(mode)
  );

  // {index, write data, expected read}
  localparam logic [133:0] VEC [6] = '{
    {6'd0,  64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF},
    {6'd62, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {6'd63, 64'hDEAD_BEEF_CAFE_F00D, 64'h0},
    {6'd15, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001},
    {6'd31, 64'hA5A5_5A5A_0F0F_F0F0, 64'hA5A5_5A5A_0F0F_F0F0},
    {6'd1,  64'h0,                   64'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cycles++;
  endtask

  task automatic idle();
    gr_we = 0; nr_we = 0; cr_we = 0; sr_we = 0; flg_we = 0; pc_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    #1;
    gr_raddr = 6'd5; cr_raddr = 4'd3; #1;
    chk("R1 gr", gr_rdata, 64'h0);
    chk("R1 cr", cr_rdata, 64'h0);
    chk("R1 sr", {32'h0, sr_rdata}, 64'h0);
    chk("R1 pc", pc_rdata, 64'h0);
    chk("R1 mode", {63'h0, mode}, 64'h0);

    // R2 R3 table of wide writes
    for (int i = 0; i < 6; i++) begin
      gr_we = 1; gr_waddr = VEC[i][133:128]; gr_wdata = VEC[i][127:64];
      tick();
      idle();
      gr_raddr = VEC[i][133:128]; #1;
      chk(VEC[i][133:128] == 6'd63 ? "R3 top zero" : "R2 readback", gr_rdata, VEC[i][63:0]);
    end

    // R2 read during write returns old value
    gr_we = 1; gr_waddr = 6'd7; gr_wdata = 64'h7777_0000_1111_2222; gr_raddr = 6'd7; #1;
    chk("R2 old during write", gr_rdata, 64'h0);
    tick(); idle(); #1;
    chk("R2 new after write", gr_rdata, 64'h7777_0000_1111_2222);

    // R4 narrow read
    gr_we = 1; gr_waddr = 6'd3; gr_wdata = 64'h1234_5678_9ABC_DEF0;
    tick(); idle();
    nr_raddr = 4'd3; #1;
    chk("R4 narrow read", {32'h0, nr_rdata}, 64'h9ABC_DEF0);

    // R5 sign extension
    nr_we = 1; nr_waddr = 4'd4; nr_wdata = 32'h8000_0001;
    tick(); idle();
    gr_raddr = 6'd4; #1;
    chk("R5 sext neg", gr_rdata, 64'hFFFF_FFFF_8000_0001);
    nr_we = 1; nr_waddr = 4'd4; nr_wdata = 32'h7FFF_FFFF;
    tick(); idle(); #1;
    chk("R5 sext pos", gr_rdata, 64'h0000_0000_7FFF_FFFF);
    gr_we = 1; gr_waddr = 6'd5; gr_wdata = 64'h1111;
    nr_we = 1; nr_waddr = 4'd5; nr_wdata = 32'h22;
    tick(); idle();
    gr_raddr = 6'd5; #1;
    chk("R5 narrow wins", gr_rdata, 64'h22);

    // R6 control register 0 aliasing
    cr_we = 1; cr_waddr = 4'd0; cr_wdata = 64'hFFFF_FFFF_0000_4302;
    tick(); idle();
    cr_raddr = 4'd0; #1;
    chk("R6 sr from cr0", {32'h0, sr_rdata}, 64'h4302);
    chk("R6 cr0 zext", cr_rdata, 64'h0000_0000_0000_4302);
    cr_we = 1; cr_waddr = 4'd2; cr_wdata = 64'hFEDC_BA98_7654_3210;
    tick(); idle();
    cr_raddr = 4'd2; #1;
    chk("R6 cr2 storage", cr_rdata, 64'hFEDC_BA98_7654_3210);
    chk("R6 cr2 no sr", {32'h0, sr_rdata}, 64'h4302);

    // R7 status write beats cr0 write
    sr_we = 1; sr_wdata = 32'h11; cr_we = 1; cr_waddr = 4'd0; cr_wdata = 64'h22;
    tick(); idle(); #1;
    chk("R7 sr priority", {32'h0, sr_rdata}, 64'h11);

    // R8 flags
    sr_we = 1; sr_wdata = 32'h0;
    tick(); idle();
    flg_we = 1; flg_sel = 3'd0; flg_wdata = 1;
    tick(); idle(); #1;
    chk("R8 bank bit14", {32'h0, sr_rdata}, 64'h4000);
    chk("R8 flag read", {58'h0, flg_rdata}, 64'h01);
    flg_we = 1; flg_sel = 3'd5; flg_wdata = 1;
    tick(); idle(); #1;
    chk("R8 sat bit1", {32'h0, sr_rdata}, 64'h4002);
    flg_we = 1; flg_sel = 3'd3; flg_wdata = 1;
    tick(); idle(); #1;
    chk("R8 M bit9", {32'h0, sr_rdata}, 64'h4202);
    chk("R8 flag read 3", {58'h0, flg_rdata}, 64'h29);
    flg_we = 1; flg_sel = 3'd6; flg_wdata = 1;
    tick(); idle(); #1;
    chk("R8 code6 ignored", {32'h0, sr_rdata}, 64'h4202);
    sr_we = 1; sr_wdata = 32'hFFFF_FFFF;
    tick(); idle();
    flg_we = 1; flg_sel = 3'd1; flg_wdata = 0;
    tick(); idle(); #1;
    chk("R8 size bit13 clear", {32'h0, sr_rdata}, 64'hFFFF_DFFF);
    flg_we = 1; flg_sel = 3'd2; flg_wdata = 0;
    tick(); idle(); #1;
    chk("R8 prec bit12 clear", {32'h0, sr_rdata}, 64'hFFFF_CFFF);

    // R9 flag overrides same-cycle whole write
    sr_we = 1; sr_wdata = 32'hFFFF_FFFF; flg_we = 1; flg_sel = 3'd4; flg_wdata = 0;
    tick(); idle(); #1;
    chk("R9 flag over word", {32'h0, sr_rdata}, 64'hFFFF_FEFF);

    // R10 PC split
    pc_we = 1; pc_wdata = 64'h0000_0000_0000_1001;
    tick(); idle(); #1;
    chk("R10 pc even", pc_rdata, 64'h1000);
    chk("R10 mode set", {63'h0, mode}, 64'h1);

    // R11 mode unaffected by other writes
    gr_we = 1; gr_waddr = 6'd9; gr_wdata = 64'h0;
    sr_we = 1; sr_wdata = 32'h0;
    cr_we = 1; cr_waddr = 4'd0; cr_wdata = 64'h0;
    nr_we = 1; nr_waddr = 4'd9; nr_wdata = 32'h0;
    tick(); idle(); #1;
    chk("R11 mode held", {63'h0, mode}, 64'h1);
    pc_we = 1; pc_wdata = 64'h2000;
    tick(); idle(); #1;
    chk("R10 mode clear", {63'h0, mode}, 64'h0);
    chk("R10 pc value", pc_rdata, 64'h2000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule